// File: doc/BRIEF.md
# Triggered DAC Data-Transfer Controller

This block is the digital front end of one 12-bit converter channel. Software writes a pending code into a holding register over a small write-only register bus. The code then moves into the output register that drives the converter. With triggering off, the move follows the write directly. With triggering on, the move waits for an event on a selected source. The output register is presented as `dac_code`. An analog model turns it into a level equal to the reference voltage times `dac_code` / 4096.

The trigger source is picked by a 3-bit select field. It can be one of six timer trigger lines, one external interrupt line, or a software request bit. Hardware lines act on their rising edge only. A detected trigger snapshots the holding register and lands it in the output register after a fixed three-cycle countdown. The software request bit clears itself once its transfer is launched.

The write port uses a valid/ready handshake. `wr_ready` is always high, so the block never applies back-pressure. A write takes effect on every clock edge where `wr_valid` is high, and a master may issue one write per cycle.

Top module: `dac_xfer_ctrl`

## Requirements
- R1: After reset, `dac_code`, the holding register, the enable bit, the select field and the software request bit are all zero.
- R2: A write with `wr_addr`=1 loads `wr_data[11:0]` into the holding register. When the enable bit is 0, `dac_code` shows that value one cycle after the write edge and not earlier.
- R3: When the enable bit is 1, holding-register writes leave `dac_code` unchanged until a trigger occurs.
- R4: A write with `wr_addr`=0 sets the control fields: bit 0 is the enable bit, bits [3:1] are the select field, and bit 4 is the software request bit. Select codes 0 to 5 choose `hw_trig[0]` to `hw_trig[5]` (the timer lines), code 6 chooses `hw_trig[6]` (the interrupt line), and code 7 chooses the software request bit.
- R5: A hardware source triggers on a 0-to-1 transition only. A line held high causes exactly one transfer.
- R6: The output register takes the snapshot three clock edges after the edge at which the trigger is detected.
- R7: Edges on sources that are not selected have no effect on `dac_code`.
- R8: Changing the select field onto a line that is already high does not trigger a transfer. A later rising edge on that line does.
- R9: With select code 7 and the enable bit set, a software request launches one transfer in the cycle after it is written. The bit then clears, so a single request yields exactly one transfer.
- R10: A trigger that arrives while a transfer is pending restarts the three-cycle countdown. The transfer then uses the holding value captured at the latest trigger, and later holding writes do not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Always 1; a write is accepted on every cycle |
| wr_addr | input | 1 | 0 selects the control register, 1 selects the holding register |
| wr_data | input | 16 | Write data |
| hw_trig | input | 7 | Hardware trigger lines: [5:0] timers, [6] interrupt line |
| dac_code | output | 12 | Output register code for the converter |

## Verification
The transfer path is driven with four patterns. Plain writes with triggering off separate the direct path from the triggered one. Single rising edges on each of the seven hardware lines in turn confirm that the select decode maps every code to its own line. Lines held high, edges on unselected lines, and a select change onto a line that is already high each show that only true rising edges of the chosen source count. A software request followed by silence, and a double trigger with a holding write between the two and another after, show that the request clears itself, that the countdown restarts, and that the snapshot is taken at the latest trigger.

// File: rtl/dac_xfer_pkg.sv
package dac_xfer_pkg;
  localparam logic ADDR_CTRL   = 1'b0;
  localparam logic ADDR_DATA   = 1'b1;
  localparam int   CTRL_EN_BIT = 0;
  localparam int   CTRL_SEL_LSB = 1;
endpackage

// File: rtl/dac_regs.sv
module dac_regs
  import dac_xfer_pkg::*;
#(
  parameter int DW   = 12,
  parameter int BUSW = 16,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_fire,
  input  logic            wr_addr,
  input  logic [BUSW-1:0] wr_data,
  input  logic            sw_consume,
  output logic [DW-1:0]   hold_q,
  output logic            hold_upd,
  output logic            en_q,
  output logic [SELW-1:0] sel_q,
  output logic            sw_q
);
  localparam int SW_BIT = CTRL_SEL_LSB + SELW;

  logic unused_hi;
  assign unused_hi = &wr_data[BUSW-1:DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      hold_upd <= 1'b0;
      en_q     <= 1'b0;
      sel_q    <= '0;
      sw_q     <= 1'b0;
    end else begin
      hold_upd <= 1'b0;
      if (wr_fire && wr_addr == ADDR_DATA) begin
        hold_q   <= wr_data[DW-1:0];
        hold_upd <= 1'b1;
      end
      if (wr_fire && wr_addr == ADDR_CTRL) begin
        en_q  <= wr_data[CTRL_EN_BIT];
        sel_q <= wr_data[CTRL_SEL_LSB +: SELW];
        sw_q  <= wr_data[SW_BIT];
      end else if (sw_consume) begin
        sw_q <= 1'b0;
      end
    end
  end

  // R9
  sw_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_consume && !(wr_fire && wr_addr == ADDR_CTRL)) |=> !sw_q);
endmodule

// File: rtl/dac_trig_sel.sv
module dac_trig_sel #(
  parameter int NHW  = 7,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [SELW-1:0] sel,
  input  logic [NHW-1:0]  hw_trig,
  input  logic            sw_q,
  output logic            launch,
  output logic            sw_consume
);
  localparam logic [SELW-1:0] SW_CODE = SELW'(NHW);

  logic            cur;
  logic            prev_q;
  logic [SELW-1:0] sel_last_q;
  logic            hw_rise;

  always_comb begin
    cur = 1'b0;
    for (int i = 0; i < NHW; i++) begin
      if (sel == SELW'(i)) cur = hw_trig[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= 1'b0;
      sel_last_q <= '0;
    end else begin
      prev_q     <= cur;
      sel_last_q <= sel;
    end
  end

  assign hw_rise    = cur && !prev_q && (sel == sel_last_q) && (sel != SW_CODE);
  assign sw_consume = en && (sel == SW_CODE) && sw_q;
  assign launch     = (en && hw_rise) || sw_consume;

  // R8
  no_false_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel) && sel != SW_CODE) |-> !launch);

  // R5
  edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && sel != SW_CODE) |=> !(launch && sel != SW_CODE && $stable(sel)));
endmodule

// File: rtl/dac_xfer_pipe.sv
module dac_xfer_pipe #(
  parameter int DW  = 12,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          launch,
  input  logic [DW-1:0] hold,
  input  logic          hold_upd,
  output logic [DW-1:0] code_q
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
      code_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
      if (hold_upd) code_q <= hold;
    end else if (launch) begin
      cnt_q  <= CW'(LAT);
      snap_q <= hold;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) code_q <= snap_q;
    end
  end

  // R3
  no_idle_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q == '0 && !launch) |=> $stable(code_q));

  generate
    if (LAT == 3) begin : g_lat3
      // R6
      latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch ##1 (en && !launch) ##1 (en && !launch) ##1 (en && !launch))
        |=> (code_q == $past(hold, 4)));
    end
  endgenerate
endmodule

// File: rtl/dac_xfer_ctrl.sv
module dac_xfer_ctrl
  import dac_xfer_pkg::*;
#(
  parameter int DW   = 12,
  parameter int BUSW = 16,
  parameter int NHW  = 7,
  parameter int LAT  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic            wr_addr,
  input  logic [BUSW-1:0] wr_data,
  input  logic [NHW-1:0]  hw_trig,
  output logic [DW-1:0]   dac_code
);
  localparam int SELW = $clog2(NHW + 1);

  logic            wr_fire;
  logic [DW-1:0]   hold_q;
  logic            hold_upd;
  logic            en_q;
  logic [SELW-1:0] sel_q;
  logic            sw_q;
  logic            sw_consume;
  logic            launch;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  dac_regs #(.DW(DW), .BUSW(BUSW), .SELW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .sw_consume(sw_consume), .hold_q(hold_q),
    .hold_upd(hold_upd), .en_q(en_q), .sel_q(sel_q), .sw_q(sw_q)
  );

  dac_trig_sel #(.NHW(NHW), .SELW(SELW)) u_sel (
    .clk(clk), .rst_n(rst_n), .en(en_q), .sel(sel_q), .hw_trig(hw_trig),
    .sw_q(sw_q), .launch(launch), .sw_consume(sw_consume)
  );

  dac_xfer_pipe #(.DW(DW), .LAT(LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .en(en_q), .launch(launch), .hold(hold_q),
    .hold_upd(hold_upd), .code_q(dac_code)
  );

  // R2
  direct_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == ADDR_DATA && !en_q) |=> ##1 (dac_code == $past(wr_data[DW-1:0], 2)));
endmodule

// File: tb/sim_dac_xfer_ctrl.sv
module sim_dac_xfer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic        wr_ready;
  logic        wr_addr;
  logic [15:0] wr_data;
  logic [6:0]  hw_trig;
  logic [11:0] dac_code;

  always #4 clk = ~clk;

  dac_xfer_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .hw_trig(hw_trig), .dac_code(dac_code)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    logic [11:0] val;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [11:0] cur;

  task automatic expect_at(input int at, input logic [11:0] v, input string tag);
    exp_t e;
    e.at = at; e.val = v; e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor: compares the output against every item due in this cycle
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = sbq.size() - 1; i >= 0; i--) begin
        if (sbq[i].at == cyc) begin
          n_run++;
          if (dac_code !== sbq[i].val) begin
            n_fail++;
            $display("FAIL %s cycle %0d: dac_code actual=%h expected=%h",
                     sbq[i].tag, cyc, dac_code, sbq[i].val);
          end
          sbq.delete(i);
        end
      end
    end
  end

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic bus_wr(input logic a, input logic [15:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wr_hold(input logic [11:0] v);
    bus_wr(1'b1, {4'h0, v});
  endtask

  task automatic wr_ctrl(input logic en, input logic [2:0] sel, input logic sw);
    bus_wr(1'b0, {11'b0, sw, sel, en});
  endtask

  initial begin
    int n;
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = 1'b0; wr_data = '0; hw_trig = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    n_run++;
    if (wr_ready !== 1'b1) begin
      n_fail++; $display("FAIL R1 wr_ready actual=%b expected=1", wr_ready);
    end
    expect_at(cyc + 1, 12'h000, "R1");
    idle(2);
    cur = 12'h000;

    // R2: direct path, one cycle after write edge
    n = cyc; wr_hold(12'hABC);
    expect_at(n + 1, cur, "R2");
    expect_at(n + 2, 12'hABC, "R2");
    cur = 12'hABC;
    idle(3);

    // R3: enabled, write does not move output
    wr_ctrl(1'b1, 3'd0, 1'b0);
    n = cyc; wr_hold(12'h123);
    expect_at(n + 2, cur, "R3");
    expect_at(n + 5, cur, "R3");
    idle(6);

    // R6: edge on timer line 0, lands three edges after detection
    n = cyc; hw_trig[0] = 1'b1;
    expect_at(n + 3, cur, "R6");
    expect_at(n + 4, 12'h123, "R6");
    cur = 12'h123;
    idle(1);

    // R5: line held high yields no second transfer
    wr_hold(12'h456);
    n = cyc;
    expect_at(n + 6, cur, "R5");
    idle(7);
    hw_trig[0] = 1'b0;
    idle(2);

    // R4: each hardware select code maps to its own line
    for (int s = 1; s < 7; s++) begin
      logic [11:0] v;
      v = 12'(12'h100 * s + s);
      wr_ctrl(1'b1, 3'(s), 1'b0);
      wr_hold(v);
      idle(1);
      n = cyc; hw_trig[s] = 1'b1;
      expect_at(n + 4, v, "R4");
      cur = v;
      idle(6);
      hw_trig[s] = 1'b0;
      idle(1);
    end

    // R7: unselected lines ignored
    wr_ctrl(1'b1, 3'd2, 1'b0);
    wr_hold(12'h777);
    n = cyc; hw_trig[3] = 1'b1; hw_trig[5] = 1'b1;
    expect_at(n + 6, cur, "R7");
    idle(7);
    hw_trig[3] = 1'b0; hw_trig[5] = 1'b0;

    // R8: select change onto a high line is not an edge
    hw_trig[4] = 1'b1;
    idle(2);
    n = cyc; wr_ctrl(1'b1, 3'd4, 1'b0);
    expect_at(n + 6, cur, "R8");
    idle(7);
    hw_trig[4] = 1'b0;
    idle(1);
    n = cyc; hw_trig[4] = 1'b1;
    expect_at(n + 4, 12'h777, "R8");
    cur = 12'h777;
    idle(6);
    hw_trig[4] = 1'b0;
    idle(1);

    // R9: software request, one transfer, then self-clears
    wr_hold(12'h9A5);
    n = cyc; wr_ctrl(1'b1, 3'd7, 1'b1);
    expect_at(n + 4, cur, "R9");
    expect_at(n + 5, 12'h9A5, "R9");
    cur = 12'h9A5;
    idle(6);
    wr_hold(12'h5A9);
    n = cyc;
    expect_at(n + 8, cur, "R9");
    idle(9);

    // R10: retrigger restarts countdown, snapshot at latest trigger
    wr_ctrl(1'b1, 3'd0, 1'b0);
    wr_hold(12'hAAA);
    idle(1);
    n = cyc; hw_trig[0] = 1'b1;
    @(negedge clk);
    hw_trig[0] = 1'b0;
    wr_hold(12'hBBB);
    hw_trig[0] = 1'b1;
    wr_hold(12'hCCC);
    expect_at(n + 4, cur, "R10");
    expect_at(n + 5, cur, "R10");
    expect_at(n + 6, 12'hBBB, "R10");
    expect_at(n + 9, 12'hBBB, "R10");
    idle(10);
    hw_trig[0] = 1'b0;
    idle(3);

    n_run++;
    if (sbq.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: pending actual=%0d expected=0", sbq.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R1..: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule